// File: doc/BRIEF.md
# Byte-Serial Address/Data Bridge

The bridge connects a requester that issues 32-bit addresses to a memory controller whose data path is only one byte wide. When the requester strobes a new address, the bridge latches it and shifts it out over the outgoing byte lane, least significant byte first, one byte per clock. A single-cycle start marker accompanies the first byte so the controller can frame the address.

After the last address byte the bridge waits, for as long as needed, until the controller signals ready. It then takes four bytes from the incoming lane on consecutive clocks, packs them least significant byte first into a 32-bit word, places the word on the data output and raises the data-ready flag. While a transfer is in flight data-ready is low and further address strobes are ignored. One request is handled at a time.

Top module: `byte_lane_bridge`

## Requirements
- R1: After reset (asynchronous, active-low `rst_ni`) `lane_o` is 0, `start_o` is 0, `data_rdy_o` is 0 and `data_o` is 0.
- R2: In idle, `new_addr_i` sampled high at a rising edge latches `addr_i`, and `data_rdy_o` is low from the following cycle until the transfer completes.
- R3: In the four cycles after the accepting edge `lane_o` carries address bits 7:0, 15:8, 23:16 and 31:24 in that order, one cycle each.
- R4: `start_o` is high only in the cycle carrying address bits 7:0, never for two consecutive cycles.
- R5: `new_addr_i` and a changed `addr_i` have no effect while a transfer is in progress; the bytes sent and received are those of the accepted request.
- R6: After the fourth address byte the bridge waits any number of cycles for `ready_i` sampled high; `ready_i` during the address phase is ignored, and `lane_o` is 0 whenever no address byte is being sent.
- R7: The four rising edges after the edge that samples `ready_i` high capture `lane_i` into result bits 7:0, 15:8, 23:16 and 31:24 in that order.
- R8: From the cycle after the fourth capture edge, `data_o` shows the assembled word and `data_rdy_o` is high; the bridge is idle again and accepts a new address.
- R9: `data_o` holds its value until the next transfer completes, including throughout a transfer.
- R10: Reset during any phase abandons the transfer at once: `start_o` and `lane_o` go to 0, `data_rdy_o` goes low, and the bridge returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| new_addr_i | input | 1 | New-address strobe from requester |
| addr_i | input | 32 | Requested address |
| lane_o | output | 8 | Outgoing byte lane to memory controller |
| lane_i | input | 8 | Incoming byte lane from memory controller |
| start_o | output | 1 | Marks the first address byte |
| ready_i | input | 1 | Controller has data to return |
| data_o | output | 32 | Assembled 32-bit result |
| data_rdy_o | output | 1 | Result valid, bridge idle |

## Verification
The bench pokes the address strobe and the ready input during the address phase: a bridge that restarted or jumped ahead would send wrong bytes or miss the start marker. Zero and long ready delays check that the wait state neither skips nor hangs, and an off-by-one capture would pack a stale lane value into the word. Reset is applied during the address and the data-return phase, where a bridge that let the abandoned transfer finish would raise data-ready or leave a byte on the lane, and idle periods after completion catch a data output that drifts.

// File: rtl/bb_pkg.sv
package bb_pkg;
  typedef enum logic [1:0] {
    BB_IDLE,
    BB_SEND,
    BB_WAIT,
    BB_RECV
  } bb_state_e;
endpackage

// File: rtl/bb_ctrl.sv
module bb_ctrl #(
  parameter int NBYTES = 4,
  localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             new_addr_i,
  input  logic             ready_i,
  output logic             accept_o,
  output logic             send_o,
  output logic             load_o,
  output logic             done_o,
  output logic [IDX_W-1:0] idx_o
);
  import bb_pkg::*;

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NBYTES - 1);

  bb_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign accept_o = (state_q == BB_IDLE) && new_addr_i;
  assign send_o   = (state_q == BB_SEND);
  assign load_o   = (state_q == BB_RECV);
  assign done_o   = load_o && (idx_q == LAST);
  assign idx_o    = idx_q;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    unique case (state_q)
      BB_IDLE: if (new_addr_i) begin
        state_d = BB_SEND;
        idx_d   = '0;
      end
      BB_SEND: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST) begin
          state_d = BB_WAIT;
          idx_d   = '0;
        end
      end
      BB_WAIT: if (ready_i) begin
        state_d = BB_RECV;
        idx_d   = '0;
      end
      BB_RECV: begin
        idx_d = idx_q + 1'b1;
        if (idx_q == LAST) begin
          state_d = BB_IDLE;
          idx_d   = '0;
        end
      end
      default: state_d = BB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BB_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

  // R6
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BB_WAIT && !ready_i) |=> (state_q == BB_WAIT));

  // R5
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == BB_SEND && idx_q != LAST) |=> (state_q == BB_SEND));
endmodule

// File: rtl/bb_addr_ser.sv
module bb_addr_ser #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8,
  localparam int NBYTES = ADDR_W / LANE_W,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              send_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [LANE_W-1:0] byte_o,
  output logic              start_o
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (accept_i) addr_q <= addr_i;
  end

  assign byte_o  = send_i ? addr_q[idx_i*LANE_W +: LANE_W] : '0;
  assign start_o = send_i && (idx_i == '0);

  // R3
  second_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> (byte_o == addr_q[2*LANE_W-1:LANE_W]));
endmodule

// File: rtl/bb_collect.sv
module bb_collect #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8,
  localparam int NBYTES = ADDR_W / LANE_W,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              load_i,
  input  logic              done_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LANE_W-1:0] byte_i,
  output logic [ADDR_W-1:0] data_o,
  output logic              rdy_o
);
  logic [ADDR_W-1:0] buf_q, buf_d;

  always_comb begin
    buf_d = buf_q;
    buf_d[idx_i*LANE_W +: LANE_W] = byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      data_o <= '0;
      rdy_o  <= 1'b0;
    end else begin
      if (load_i) buf_q <= buf_d;
      if (done_i) begin
        data_o <= buf_d;
        rdy_o  <= 1'b1;
      end else if (accept_i) begin
        rdy_o  <= 1'b0;
      end
    end
  end

  // R2
  rdy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rdy_o) |-> $past(accept_i));

  // R9
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(data_o));
endmodule

// File: rtl/byte_lane_bridge.sv
module byte_lane_bridge #(
  parameter int ADDR_W = 32,
  parameter int LANE_W = 8,
  localparam int NBYTES = ADDR_W / LANE_W,
  localparam int IDX_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              new_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [LANE_W-1:0] lane_o,
  input  logic [LANE_W-1:0] lane_i,
  output logic              start_o,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] data_o,
  output logic              data_rdy_o
);
  logic             accept, send, load, done;
  logic [IDX_W-1:0] idx;

  bb_ctrl #(.NBYTES(NBYTES)) i_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .new_addr_i(new_addr_i),
    .ready_i   (ready_i),
    .accept_o  (accept),
    .send_o    (send),
    .load_o    (load),
    .done_o    (done),
    .idx_o     (idx)
  );

  bb_addr_ser #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .addr_i  (addr_i),
    .send_i  (send),
    .idx_i   (idx),
    .byte_o  (lane_o),
    .start_o (start_o)
  );

  bb_collect #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_col (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .accept_i(accept),
    .load_i  (load),
    .done_i  (done),
    .idx_i   (idx),
    .byte_i  (lane_i),
    .data_o  (data_o),
    .rdy_o   (data_rdy_o)
  );

  // R4
  start_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  // R8
  rdy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_rdy_o) |-> (lane_o == '0 && !start_o));
endmodule

// File: tb/test_byte_lane_bridge.sv
`timescale 1ns/1ps
module test_byte_lane_bridge;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        new_addr_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic [7:0]  lane_o;
  logic [7:0]  lane_i = '0;
  logic        start_o;
  logic        ready_i = 1'b0;
  logic [31:0] data_o;
  logic        data_rdy_o;

  int          n_vec = 0;
  int          n_bad = 0;
  bit          finished = 1'b0;
  logic [31:0] exp_data = '0;
  logic        exp_rdy = 1'b0;

  always #2.5 clk_i = ~clk_i;

  byte_lane_bridge i_byte_lane_bridge (
    .clk_i(clk_i), .rst_ni(rst_ni), .new_addr_i(new_addr_i), .addr_i(addr_i),
    .lane_o(lane_o), .lane_i(lane_i), .start_o(start_o), .ready_i(ready_i),
    .data_o(data_o), .data_rdy_o(data_rdy_o)
  );

  task automatic chk(input string req, input logic [7:0] e_lane, input logic e_start);
    n_vec++;
    if (lane_o !== e_lane || start_o !== e_start || data_rdy_o !== exp_rdy ||
        data_o !== exp_data) begin
      n_bad++;
      $display("FAIL %s: lane=%h start=%b rdy=%b data=%h expected lane=%h start=%b rdy=%b data=%h",
               req, lane_o, start_o, data_rdy_o, data_o, e_lane, e_start, exp_rdy, exp_data);
    end
  endtask

  // Reference: requester plus memory-controller model, checked each cycle.
  task automatic xfer(input logic [31:0] a, input logic [31:0] w, input int dly, input bit poke);
    logic [7:0] rq[$];
    for (int k = 0; k < 4; k++) rq.push_back(w[k*8 +: 8]);
    @(negedge clk_i);
    new_addr_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    new_addr_i = 1'b0; addr_i = ~a;
    exp_rdy = 1'b0;
    chk("R2 R3 R4 first byte", a[7:0], 1'b1);
    for (int k = 1; k < 4; k++) begin
      if (poke) begin new_addr_i = 1'b1; addr_i = 32'h1357_9BDF; ready_i = 1'b1; end
      @(negedge clk_i);
      chk("R3 R4 R5 address byte", a[k*8 +: 8], 1'b0);
    end
    new_addr_i = 1'b0; ready_i = 1'b0;
    @(negedge clk_i);
    chk("R6 wait entry", 8'h00, 1'b0);
    for (int d = 0; d < dly; d++) begin
      new_addr_i = poke;
      @(negedge clk_i);
      chk("R5 R6 waiting", 8'h00, 1'b0);
    end
    new_addr_i = 1'b0;
    ready_i = 1'b1; lane_i = 8'hA5;
    @(negedge clk_i);
    ready_i = 1'b0;
    for (int k = 0; k < 4; k++) begin
      lane_i = rq.pop_front();
      chk("R7 collecting", 8'h00, 1'b0);
      @(negedge clk_i);
    end
    lane_i = 8'h3C;
    exp_data = w; exp_rdy = 1'b1;
    chk("R7 R8 word ready", 8'h00, 1'b0);
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    chk("R1 reset", 8'h00, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after release", 8'h00, 1'b0);

    xfer(32'h4433_2211, 32'hDDCC_BBAA, 0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R9 hold idle", 8'h00, 1'b0);
    end
    xfer(32'h8070_6050, 32'h0123_4567, 5, 1'b1);
    xfer(32'hFFFF_0000, 32'h8000_0001, 40, 1'b1);
    xfer(32'h0000_00FF, 32'hFEDC_BA98, 2, 1'b0);

    // R10: reset in the data-return phase
    @(negedge clk_i);
    new_addr_i = 1'b1; addr_i = 32'hCAFE_F00D;
    @(negedge clk_i);
    new_addr_i = 1'b0; exp_rdy = 1'b0;
    repeat (5) @(negedge clk_i);
    ready_i = 1'b1;
    @(negedge clk_i);
    ready_i = 1'b0; lane_i = 8'h77;
    @(negedge clk_i);
    rst_ni = 1'b0; #1;
    exp_data = '0; exp_rdy = 1'b0;
    chk("R10 reset in return phase", 8'h00, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) begin
      @(negedge clk_i);
      chk("R10 abandoned stays low", 8'h00, 1'b0);
    end

    // R10: reset in the address phase
    @(negedge clk_i);
    new_addr_i = 1'b1; addr_i = 32'h1122_3344;
    @(negedge clk_i);
    new_addr_i = 1'b0;
    chk("R10 pre-reset first byte", 8'h44, 1'b1);
    #1 rst_ni = 1'b0; #1;
    chk("R10 reset in address phase", 8'h00, 1'b0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 idle after reset", 8'h00, 1'b0);

    xfer(32'h9ABC_DEF0, 32'h5A5A_C3C3, 1, 1'b1);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk_i);
      chk("R9 R8 hold after completion", 8'h00, 1'b0);
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run not complete, expected completion within 20000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule